// File: doc/BRIEF.md
# Bus Target Transaction Phase Decoder

This block sits passively on a 32-bit multiplexed address/data bus and follows each transaction from its address phase to its final data phase. When the cycle frame is asserted while the block is idle, it takes the address and the four-bit command from that clock. It reports the command as one of a small set of transaction classes and announces the start with a one-cycle strobe. The block never drives the bus. Target selection, address range matching, parity and wide transfers belong to other logic.

During the data phases the block counts beats. A beat completes on a clock where both the initiator-ready and target-ready lines are sampled low. Each completed beat raises one of two strobes. The accept strobe means every byte lane was enabled. The discard strobe means at least one lane was disabled. A discarded beat still completes normally on the bus, but downstream logic must drop it rather than perform a partial write. Each beat carries its data word, an address that advances by one word per completed beat, and a flag that marks the final beat.

The beat and start outputs form a stream that cannot be stalled. A passive observer cannot hold off the bus, so there is no ready input. Downstream logic must take every strobe in the cycle in which it is high. All outputs are registered and appear one clock after the sampling edge.

Top module: `pci_tgt_phase_dec`

## Requirements
- R1: While reset is asserted and after it is released, the block is idle. Every strobe is low, `busy` is low, and the address, data and class outputs are zero.
- R2: On the first rising edge where `frame_n` is low while the block is idle, the block captures `ad` and `cbe_n`. One clock later `txn_start` is high for exactly one cycle, `txn_addr` equals the captured address, and `busy` is high.
- R3: The command is reported on `txn_class` with this mapping. Commands 0110, 1100 and 1110 give 1 (memory read). Commands 0111 and 1111 give 2 (memory write). Command 1010 gives 3 (configuration read). Command 1011 gives 4 (configuration write). Every other command gives 0 (other). `txn_class` holds its value until the next address phase.
- R4: A data beat completes only on an edge where the block is busy and both `irdy_n` and `trdy_n` are low. The beat strobe appears one clock later. Clocks where either ready line is high produce no strobe.
- R5: For each completed beat, exactly one strobe goes high. `beat_accept` is raised when all four `cbe_n` bits were 0 at that edge, and `beat_discard` is raised otherwise.
- R6: `beat_addr` for the n-th completed beat of a transaction (counting from 0) equals the captured address plus 4*n, modulo 2^32.
- R7: `beat_data` equals `ad` at the completing edge.
- R8: A beat whose completing edge sees `frame_n` high is the final beat. `beat_last` is raised with its strobe and `busy` falls in the same cycle. A new address phase may begin on the very next edge.
- R9: If `frame_n` and `irdy_n` are both high on an edge while busy, the block returns to idle with no beat strobe.
- R10: While idle, ready lines that are low produce no strobe. While busy, `frame_n` low with new `ad`/`cbe_n` values does not restart capture: `txn_addr` and `txn_class` stay unchanged and `txn_start` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Cycle frame from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| ad | input | 32 | Multiplexed address/data bus |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| busy | output | 1 | High from the clock after the address phase until the transaction ends |
| txn_start | output | 1 | One-cycle strobe marking a captured address phase |
| txn_addr | output | 32 | Address captured in the last address phase |
| txn_class | output | 3 | Class of the last captured command (see R3) |
| beat_accept | output | 1 | Completed beat with every byte lane enabled |
| beat_discard | output | 1 | Completed beat with at least one lane disabled |
| beat_addr | output | 32 | Word address of the reported beat |
| beat_data | output | 32 | Data word of the reported beat |
| beat_last | output | 1 | Reported beat is the final one of its transaction |

## Verification
The hardest cases to reach from the ports are the timing edges of a transaction. One is a final beat followed at once by a new address phase, with no idle clock between them. Another is a final phase held back by wait states while the cycle frame must stay asserted. The stimulus generator builds transactions of random length, random wait states on either ready line and random byte-enable patterns. It randomly leaves out the idle gap between transactions. Directed cases add an aborted transaction, ready lines pulled low while idle, and an address that wraps past the top of the space.

// File: rtl/pcit_pkg.sv
package pcit_pkg;

  typedef enum logic [2:0] {
    CLS_OTHER  = 3'd0,
    CLS_MEM_RD = 3'd1,
    CLS_MEM_WR = 3'd2,
    CLS_CFG_RD = 3'd3,
    CLS_CFG_WR = 3'd4
  } cmd_class_e;

  localparam int unsigned CMD_W = 4;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

endpackage

// File: rtl/pcit_cmd_decode.sv
module pcit_cmd_decode
  import pcit_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output cmd_class_e       cls
);

  always_comb begin
    unique case (cmd)
      4'b0110, 4'b1100, 4'b1110: cls = CLS_MEM_RD;
      4'b0111, 4'b1111:          cls = CLS_MEM_WR;
      4'b1010:                   cls = CLS_CFG_RD;
      4'b1011:                   cls = CLS_CFG_WR;
      default:                   cls = CLS_OTHER;
    endcase
  end

endmodule

// File: rtl/pcit_phase_fsm.sv
module pcit_phase_fsm
  import pcit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic trdy_n,
  output logic addr_phase,
  output logic beat_done,
  output logic beat_final,
  output logic busy
);

  phase_e state_q, state_d;
  logic   abort;

  assign addr_phase = (state_q == PH_IDLE) && !frame_n;
  assign beat_done  = (state_q == PH_DATA) && !irdy_n && !trdy_n;
  assign beat_final = beat_done && frame_n;
  assign abort      = (state_q == PH_DATA) && frame_n && irdy_n;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: if (addr_phase) state_d = PH_DATA;
      PH_DATA: if (beat_final || abort) state_d = PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q == PH_DATA);

  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy); // R9

endmodule

// File: rtl/pcit_beat_out.sv
module pcit_beat_out
  import pcit_pkg::*;
#(
  parameter int unsigned AD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_phase,
  input  logic              beat_done,
  input  logic              beat_final,
  input  logic [AD_W-1:0]   ad,
  input  logic [AD_W/8-1:0] be_n,
  input  cmd_class_e        cls,
  output logic              txn_start,
  output logic [AD_W-1:0]   txn_addr,
  output cmd_class_e        txn_class,
  output logic              beat_accept,
  output logic              beat_discard,
  output logic [AD_W-1:0]   beat_addr,
  output logic [AD_W-1:0]   beat_data,
  output logic              beat_last
);

  localparam int unsigned BE_W = AD_W / 8;
  localparam logic [AD_W-1:0] STEP = AD_W'(BE_W);

  logic [AD_W-1:0] cur_addr;
  logic            all_lanes;

  assign all_lanes = (be_n == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      txn_start <= 1'b0;
      txn_addr  <= '0;
      txn_class <= CLS_OTHER;
    end else begin
      txn_start <= addr_phase;
      if (addr_phase) begin
        cur_addr  <= ad;
        txn_addr  <= ad;
        txn_class <= cls;
      end else if (beat_done) begin
        cur_addr <= cur_addr + STEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_accept  <= 1'b0;
      beat_discard <= 1'b0;
      beat_last    <= 1'b0;
      beat_addr    <= '0;
      beat_data    <= '0;
    end else begin
      beat_accept  <= beat_done && all_lanes;
      beat_discard <= beat_done && !all_lanes;
      beat_last    <= beat_final;
      if (beat_done) begin
        beat_addr <= cur_addr;
        beat_data <= ad;
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat_accept && beat_discard)); // R5
  AST_ACCEPT_FULL_BE: assert property (@(posedge clk) disable iff (!rst_n)
    beat_accept |-> $past(be_n) == '0); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((beat_accept || beat_discard) && $past(beat_accept || beat_discard) && !$past(beat_last))
      |-> beat_addr == $past(beat_addr) + STEP); // R6
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |=> !txn_start); // R2

endmodule

// File: rtl/pci_tgt_phase_dec.sv
module pci_tgt_phase_dec
  import pcit_pkg::*;
#(
  parameter int unsigned AD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic [AD_W-1:0]   ad,
  input  logic [AD_W/8-1:0] cbe_n,
  output logic              busy,
  output logic              txn_start,
  output logic [AD_W-1:0]   txn_addr,
  output logic [2:0]        txn_class,
  output logic              beat_accept,
  output logic              beat_discard,
  output logic [AD_W-1:0]   beat_addr,
  output logic [AD_W-1:0]   beat_data,
  output logic              beat_last
);

  localparam int unsigned BE_W = AD_W / 8;

  logic       addr_phase, beat_done, beat_final;
  cmd_class_e cls, cls_q;

  pcit_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .trdy_n     (trdy_n),
    .addr_phase (addr_phase),
    .beat_done  (beat_done),
    .beat_final (beat_final),
    .busy       (busy)
  );

  pcit_cmd_decode u_dec (
    .cmd (cbe_n[CMD_W-1:0]),
    .cls (cls)
  );

  pcit_beat_out #(.AD_W(AD_W)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_phase   (addr_phase),
    .beat_done    (beat_done),
    .beat_final   (beat_final),
    .ad           (ad),
    .be_n         (cbe_n[BE_W-1:0]),
    .cls          (cls),
    .txn_start    (txn_start),
    .txn_addr     (txn_addr),
    .txn_class    (cls_q),
    .beat_accept  (beat_accept),
    .beat_discard (beat_discard),
    .beat_addr    (beat_addr),
    .beat_data    (beat_data),
    .beat_last    (beat_last)
  );

  assign txn_class = cls_q;

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |-> (busy && !$past(busy))); // R2
  AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |-> txn_class <= 3'd4); // R3
  AST_BEAT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_accept || beat_discard) |-> $past(busy)); // R4
  AST_LAST_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> !busy); // R8
  AST_CLASS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_start |-> $stable(txn_class)); // R10

endmodule

// File: tb/test_pci_tgt_phase_dec.sv
module test_pci_tgt_phase_dec;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic        busy, txn_start, beat_accept, beat_discard, beat_last;
  logic [31:0] txn_addr, beat_addr, beat_data;
  logic [2:0]  txn_class;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pci_tgt_phase_dec i_pci_tgt_phase_dec (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .ad(ad), .cbe_n(cbe_n), .busy(busy),
    .txn_start(txn_start), .txn_addr(txn_addr), .txn_class(txn_class),
    .beat_accept(beat_accept), .beat_discard(beat_discard),
    .beat_addr(beat_addr), .beat_data(beat_data), .beat_last(beat_last)
  );

  function automatic logic [2:0] exp_class(input logic [3:0] c);
    if (c == 4'b0110 || c == 4'b1100 || c == 4'b1110) return 3'd1;
    if (c == 4'b0111 || c == 4'b1111) return 3'd2;
    if (c == 4'b1010) return 3'd3;
    if (c == 4'b1011) return 3'd4;
    return 3'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic no_strobe(input string req);
    chk(!beat_accept && !beat_discard && !beat_last, req,
        {29'd0, beat_accept, beat_discard, beat_last}, 32'd0);
  endtask

  task automatic idle_cycle();
    frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1;
    ad = $urandom; cbe_n = 4'($urandom);
    @(negedge clk);
  endtask

  // drives one transaction; leaves the bus as it was on the final beat
  task automatic run_txn(input logic [3:0] cmd, input logic [31:0] addr,
                         input int nbeats, input bit full_be_bias, input int max_wait);
    logic [31:0] d;
    logic [3:0]  be;
    frame_n = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1; ad = addr; cbe_n = cmd;
    @(negedge clk);
    chk(txn_start && busy, "R2 start", {30'd0, txn_start, busy}, 32'd3);
    chk(txn_addr == addr, "R2 addr", txn_addr, addr);
    chk(txn_class == exp_class(cmd), "R3 class", 32'(txn_class), 32'(exp_class(cmd)));
    for (int b = 0; b < nbeats; b++) begin
      int w;
      w = (max_wait > 0) ? int'($urandom_range(max_wait, 0)) : 0;
      for (int k = 0; k < w; k++) begin
        frame_n = 1'b0;
        ad = $urandom; cbe_n = 4'($urandom);
        case ($urandom_range(2, 0))
          0: begin irdy_n = 1'b1; trdy_n = 1'b0; end
          1: begin irdy_n = 1'b0; trdy_n = 1'b1; end
          default: begin irdy_n = 1'b1; trdy_n = 1'b1; end
        endcase
        @(negedge clk);
        no_strobe("R4 wait state");
        chk(!txn_start && txn_addr == addr, "R10 no recapture", txn_addr, addr);
      end
      d  = $urandom;
      be = (full_be_bias && ($urandom_range(1, 0) == 0)) ? 4'h0 : 4'($urandom);
      frame_n = (b == nbeats - 1); irdy_n = 1'b0; trdy_n = 1'b0; ad = d; cbe_n = be;
      @(negedge clk);
      chk(beat_accept == (be == 4'h0) && beat_discard == (be != 4'h0), "R5 strobe",
          {30'd0, beat_accept, beat_discard}, {30'd0, be == 4'h0, be != 4'h0});
      chk(beat_addr == addr + 32'(4 * b), "R6 beat addr", beat_addr, addr + 32'(4 * b));
      chk(beat_data == d, "R7 beat data", beat_data, d);
      chk(beat_last == (b == nbeats - 1), "R8 last flag", 32'(beat_last), 32'(b == nbeats - 1));
      if (b == nbeats - 1)
        chk(!busy, "R8 idle after final", 32'(busy), 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !txn_start && !beat_accept && !beat_discard && !beat_last &&
        txn_addr == 0 && beat_addr == 0 && beat_data == 0 && txn_class == 0,
        "R1 reset state", {27'd0, busy, txn_start, beat_accept, beat_discard, beat_last}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R1 idle after reset", 32'(busy), 32'd0);

    // R10: ready lines low while idle
    frame_n = 1'b1; irdy_n = 1'b0; trdy_n = 1'b0; cbe_n = 4'h0;
    @(negedge clk);
    no_strobe("R10 idle readies");
    chk(!busy, "R10 stays idle", 32'(busy), 32'd0);
    @(negedge clk);
    no_strobe("R10 idle readies");

    // R3: every command code, single beat
    for (int c = 0; c < 16; c++) begin
      run_txn(4'(c), 32'h1000_0000 + 32'(c * 64), 1, 1'b1, 0);
      idle_cycle();
    end

    // R9: abort after address phase
    frame_n = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1; ad = 32'h2222_0000; cbe_n = 4'b0111;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b0; cbe_n = 4'h0;
    @(negedge clk);
    no_strobe("R9 abort");
    chk(!busy, "R9 abort idles", 32'(busy), 32'd0);

    // R6: wrap of address past top
    run_txn(4'b0111, 32'hFFFF_FFF8, 4, 1'b1, 1);

    // R8: back-to-back without idle gap
    run_txn(4'b0110, 32'h0000_4000, 2, 1'b1, 0);
    run_txn(4'b1011, 32'h0000_8000, 3, 1'b0, 2);
    idle_cycle();

    // random mix
    void'($urandom(32'h5EED_1234));
    for (int t = 0; t < 60; t++) begin
      run_txn(4'($urandom), {$urandom} & 32'hFFFF_FFFC, int'($urandom_range(5, 1)),
              1'b1, int'($urandom_range(2, 0)));
      if ($urandom_range(1, 0) == 1) idle_cycle();
    end
    idle_cycle();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule